// File: doc/BRIEF.md
# Master Event Status Register with Read-Snapshot Clearing

This block holds the sticky event flags that a serial bus master engine reports when a transaction ends. There are five flags: arbitration lost after the target address phase, transaction timeout, NACK received, bus arbitration timeout, and clean completion. The engine raises each flag with a one-cycle pulse. A boot-failure pulse from the boot loader can also raise the first three flags.

Software reaches the block through a small register bus. It has an address, separate read and write strobes, 32-bit write data and registered read data. Every read of the status word records the flags it returned as a snapshot. A following write-one-to-clear can only drop flags that are set in both the write data and that snapshot. An event that arrives between the read and the write therefore stays set until software has seen it. A second word holds per-flag interrupt enables, and a single interrupt line shows whether any enabled flag is set.

Top module: `mtx_event_status`

## Requirements
- R1: After reset, every flag, every enable and the snapshot are 0, and `irqOut` and `regRdata` are 0.
- R2: A one-cycle pulse on `evtPulse[i]` sets flag i from the next clock edge, and the flag stays set until it is cleared. Index 0 is collision, 1 is timeout, 2 is NACK, 3 is arbitration timeout and 4 is completion.
- R3: A `bootFail` pulse sets flags 0, 1 and 2 and does not touch flags 3 and 4.
- R4: A read at address 0x0 returns flag i in data bit 27+i, with every other bit 0. The data appears on `regRdata` after the edge where `regRd` is sampled and holds until the next read. The read also stores the flag values it returned as the snapshot.
- R5: A write at address 0x0 clears flag i only when write data bit 27+i is 1 and snapshot bit i is 1.
- R6: Every write at address 0x0 zeroes the snapshot. A write with no read before it, or a second write with no read in between, clears nothing.
- R7: An event that arrives after the snapshot read survives a write-one-to-clear of all bits.
- R8: If a pulse and a clear reach the same flag on the same edge, the flag stays 1.
- R9: Address 0x4 is the enable word. Bits 27..31 are read/write, reset to 0, and line up with the flags in the same way as in R4. All other bits read 0.
- R10: `irqOut` is 1 exactly when some flag is 1 and its enable bit is 1, from the edge that changes either one.
- R11: A read at any other address returns 0. A write there changes neither flags nor enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtPulse | input | 5 | One-cycle event pulses from the master engine |
| bootFail | input | 1 | One-cycle boot-failure pulse |
| regAddr | input | 4 | Register byte address |
| regRd | input | 1 | Read strobe |
| regWr | input | 1 | Write strobe (takes priority over a read in the same cycle) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |
| irqOut | output | 1 | Interrupt, the OR of the enabled flags |

## Verification
The clearing logic is tried with several write patterns. A read followed by a full clear shows that the snapshot guard passes legal clears. A write with no read before it, and a repeated write, show that the guard blocks clears that have not been armed. A partial mask shows that clears are made bit by bit. An event placed between the read and the write, and an event on the same edge as the clear, separate "clear what was seen" from "clear what is set now". The boot-failure pulse and the enable patterns (all enabled, none enabled, one enable that does not match a set flag) separate the flag mapping from the interrupt gating.

// File: rtl/evs_pkg.sv
package evs_pkg;
  typedef struct packed {
    logic rdStatus;
    logic wrStatus;
    logic rdEnable;
    logic wrEnable;
    logic rdOther;
  } busStrobe_t;
endpackage

// File: rtl/evs_ctrl.sv
module evs_ctrl
  import evs_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int STATUS_ADDR = 0,
  parameter int ENABLE_ADDR = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  output busStrobe_t        strobes
);
  localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(ENABLE_ADDR);

  logic hitStatus;
  logic hitEnable;
  logic rdOnly;

  assign hitStatus = (regAddr == ST_A);
  assign hitEnable = (regAddr == EN_A);
  assign rdOnly    = regRd && !regWr;

  always_comb begin
    strobes          = '0;
    strobes.wrStatus = regWr && hitStatus;
    strobes.wrEnable = regWr && hitEnable;
    strobes.rdStatus = rdOnly && hitStatus;
    strobes.rdEnable = rdOnly && hitEnable;
    strobes.rdOther  = rdOnly && !hitStatus && !hitEnable;
  end

  // At most one strobe per cycle; unmapped accesses cause no register write (R11)
  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));
  assert_unmapped_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdOther |-> !(strobes.wrStatus || strobes.wrEnable));
endmodule

// File: rtl/evs_dpath.sv
module evs_dpath
  import evs_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int EVT_N   = 5,
  parameter int EVT_LSB = 27,
  parameter int BOOT_N  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobes,
  input  logic [EVT_N-1:0]  evtPulse,
  input  logic              bootFail,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut
);
  localparam logic [EVT_N-1:0] BOOT_MASK = EVT_N'((1 << BOOT_N) - 1);

  logic [EVT_N-1:0]  status;
  logic [EVT_N-1:0]  snap;
  logic [EVT_N-1:0]  enable;
  logic [EVT_N-1:0]  setVec;
  logic [EVT_N-1:0]  clrMask;
  logic [EVT_N-1:0]  wField;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] enableWord;
  logic              unusedWdata;

  assign wField      = regWdata[EVT_LSB +: EVT_N];
  assign unusedWdata = ^regWdata;
  assign setVec      = evtPulse | (bootFail ? BOOT_MASK : '0);
  assign clrMask     = strobes.wrStatus ? (wField & snap) : '0;

  always_comb begin
    statusWord = '0;
    enableWord = '0;
    statusWord[EVT_LSB +: EVT_N] = status;
    enableWord[EVT_LSB +: EVT_N] = enable;
  end

  // Sticky flags: set beats clear on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= '0;
    else       status <= (status & ~clrMask) | setVec;
  end

  // Snapshot: refreshed by every status read, zeroed by every status write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 snap <= '0;
    else if (strobes.wrStatus) snap <= '0;
    else if (strobes.rdStatus) snap <= status;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 enable <= '0;
    else if (strobes.wrEnable) enable <= wField;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 regRdata <= '0;
    else if (strobes.rdStatus) regRdata <= statusWord;
    else if (strobes.rdEnable) regRdata <= enableWord;
    else if (strobes.rdOther)  regRdata <= '0;
  end

  assign irqOut = |(status & enable);

  for (genvar i = 0; i < EVT_N; i++) begin : g_bitChk
    assert_clear_guarded_R5: assert property (@(posedge clk) disable iff (!rstN)
      $fell(status[i]) |-> $past(strobes.wrStatus && regWdata[EVT_LSB+i] && snap[i]));
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
      setVec[i] |=> status[i]);
  end

  assert_snap_zeroed_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrStatus |=> (snap == '0));
  assert_boot_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    bootFail |=> ((status & BOOT_MASK) == BOOT_MASK));
  assert_read_data_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdStatus |=> (regRdata[EVT_LSB +: EVT_N] == $past(status)));
  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (status != '0) && (enable != '0));
endmodule

// File: rtl/mtx_event_status.sv
module mtx_event_status
  import evs_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int EVT_N       = 5,
  parameter int EVT_LSB     = 27,
  parameter int BOOT_N      = 3,
  parameter int STATUS_ADDR = 0,
  parameter int ENABLE_ADDR = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EVT_N-1:0]  evtPulse,
  input  logic              bootFail,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut
);
  busStrobe_t strobes;

  evs_ctrl #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .ENABLE_ADDR(ENABLE_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRd(regRd), .regWr(regWr),
    .strobes(strobes)
  );

  evs_dpath #(
    .DATA_W(DATA_W), .EVT_N(EVT_N), .EVT_LSB(EVT_LSB), .BOOT_N(BOOT_N)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .evtPulse(evtPulse),
    .bootFail(bootFail), .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );
endmodule

// File: tb/tb_mtx_event_status.sv
`timescale 1ns/1ps
module tb_mtx_event_status;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  evtPulse = '0;
  logic        bootFail = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regRd = 1'b0;
  logic        regWr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  logic [4:0] mStatus = '0;
  logic [4:0] mSnap = '0;
  logic [4:0] mEnable = '0;

  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdFlag = 1'b0;

  mtx_event_status dut (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .bootFail(bootFail),
    .regAddr(regAddr), .regRd(regRd), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) rdFlag <= regRd;

  // Monitor: pops one expected item per completed read
  always @(negedge clk) begin
    if (rdFlag && expQ.size() > 0) begin
      chk(tagQ.pop_front(), regRdata, expQ.pop_front());
    end
  end

  function automatic logic [31:0] place(input logic [4:0] f);
    return {f, 27'd0};
  endfunction

  task automatic doRead(input logic [3:0] addr, input string tag);
    @(negedge clk);
    regAddr = addr; regRd = 1'b1;
    if (addr == 4'h0) begin
      expQ.push_back(place(mStatus)); mSnap = mStatus;
    end else if (addr == 4'h4) expQ.push_back(place(mEnable));
    else expQ.push_back(32'd0);
    tagQ.push_back(tag);
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic doWrite(input logic [3:0] addr, input logic [31:0] d, input logic [4:0] evt);
    @(negedge clk);
    regAddr = addr; regWr = 1'b1; regWdata = d; evtPulse = evt;
    if (addr == 4'h0) begin
      mStatus = (mStatus & ~(d[31:27] & mSnap)) | evt; mSnap = '0;
    end else begin
      mStatus = mStatus | evt;
      if (addr == 4'h4) mEnable = d[31:27];
    end
    @(negedge clk);
    regWr = 1'b0; evtPulse = '0;
  endtask

  task automatic pulse(input logic [4:0] evt, input logic boot);
    @(negedge clk);
    evtPulse = evt; bootFail = boot;
    mStatus = mStatus | evt | (boot ? 5'b00111 : 5'b0);
    @(negedge clk);
    evtPulse = '0; bootFail = 1'b0;
  endtask

  task automatic chkIrq(input string tag);
    chk(tag, {31'd0, irqOut}, {31'd0, |(mStatus & mEnable)});
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata", regRdata, 32'd0);
    chk("R1 irq", {31'd0, irqOut}, 32'd0);
    rstN = 1'b1;
    doRead(4'h0, "R1 status");
    doRead(4'h4, "R1 enable");
    // R2: sticky flags
    pulse(5'b00001, 1'b0);
    repeat (2) @(negedge clk);
    doRead(4'h0, "R2 collision");
    pulse(5'b10000, 1'b0);
    doRead(4'h0, "R2 done");
    // R5: full clear after read
    doWrite(4'h0, 32'hFFFF_FFFF, '0);
    doRead(4'h0, "R5 full clear");
    // R6: no read before write, then repeated write
    pulse(5'b00100, 1'b0);
    doWrite(4'h0, 32'hF800_0000, '0);
    doRead(4'h0, "R6 write without read");
    doWrite(4'h0, 32'hF800_0000, '0);
    pulse(5'b00100, 1'b0);
    doWrite(4'h0, 32'hF800_0000, '0);
    doRead(4'h0, "R6 second write");
    doWrite(4'h0, 32'hF800_0000, '0);
    doRead(4'h0, "R5 cleared again");
    // R7: event between snapshot and clear
    pulse(5'b00010, 1'b0);
    doRead(4'h0, "R7 snapshot");
    pulse(5'b01000, 1'b0);
    doWrite(4'h0, 32'hFFFF_FFFF, '0);
    doRead(4'h0, "R7 late event kept");
    // R8: set and clear on same edge
    doWrite(4'h0, 32'hFFFF_FFFF, 5'b01000);
    doRead(4'h0, "R8 set wins");
    doWrite(4'h0, 32'hFFFF_FFFF, '0);
    doRead(4'h0, "R8 cleared later");
    // R3: boot failure
    pulse('0, 1'b1);
    doRead(4'h0, "R3 boot fail");
    // R5: partial mask clears only bit 28
    doWrite(4'h0, 32'h1000_0000, '0);
    doRead(4'h0, "R5 partial");
    // R9 / R10: enables and interrupt
    chkIrq("R10 disabled");
    doWrite(4'h4, 32'hFFFF_FFFF, '0);
    doRead(4'h4, "R9 enable readback");
    chkIrq("R10 enabled");
    doWrite(4'h4, 32'h8000_0000, '0);
    chkIrq("R10 mismatch enable");
    pulse(5'b10000, 1'b0);
    chkIrq("R10 matching flag");
    doWrite(4'h4, 32'h0000_0000, '0);
    chkIrq("R10 enables off");
    // R11: unmapped address
    doWrite(4'h8, 32'hFFFF_FFFF, '0);
    doRead(4'h8, "R11 unmapped read");
    doRead(4'h4, "R11 enable untouched");
    doRead(4'h0, "R11 status untouched");
    repeat (3) @(negedge clk);
    chk("R4 queue drained", expQ.size(), 32'd0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule